// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames from a byte-wide MAC stream into memory. Frame placement is controlled by a ring of buffer descriptors that software keeps in memory. The engine reads the descriptor at its current ring position and checks that software has handed it over as empty. Each descriptor carries a 32-bit buffer pointer, and the engine packs the incoming bytes into 32-bit words at that address. Once the last data write has completed, it writes back the stored length and a status word in a single write. It then moves on to the next descriptor, or back to the ring base when the descriptor it just used carried the wrap flag.

If the engine finds a descriptor that is not empty, it parks and raises a stalled indication. In that state it neither accepts bytes nor touches memory. Software frees descriptors and then writes the activate register, and polling resumes at the descriptor that caused the stall. The engine also parks after reset, so the first activate write starts it.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, `rx_stalled` is 1 and both `rx_ready` and `mem_req` are 0.
- R2: An `act_wr` pulse with `act_data[24]` = 1 while stalled starts a read of the current descriptor. A pulse with bit 24 = 0 has no effect, and the block stays stalled.
- R3: A descriptor takes 8 bytes. The word at its address holds status in bits [15:0] and length in bits [31:16], and the word at address+4 is the buffer pointer. Status bit 15 = 1 means the descriptor is empty and may be filled.
- R4: A fetched descriptor with status bit 15 = 0 stalls the engine. No bytes are accepted and no memory request is issued until the next valid activate write, which re-reads the same descriptor.
- R5: Byte k of a frame goes to buffer pointer + k. Byte lane k mod 4 of a 32-bit word carries it, and its strobe is set. Only the lanes that hold frame bytes are strobed, including in a partial last word.
- R6: Write-back is one 4-strobe write to the descriptor word. It carries the stored byte count (the frame check sequence included) in bits [31:16] and clears status bit 15. It is issued only after every data write of the frame has been acknowledged.
- R7: Written status always sets bit 11 and copies bit 13 from the fetched status. It sets bit 8, 7 and 6 from `rx_flags[5]`, `[4]` and `[3]` (promiscuous-only, broadcast, multicast) sampled with the last byte. All other unlisted bits are 0.
- R8: Status bit 4, 2 and 1 copy `rx_flags[2]`, `[1]` and `[0]` (non-octet, CRC error, FIFO overrun). Bit 3 is set when the stored count is below `MIN_FRAME`.
- R9: A frame longer than `MAX_FRAME` bytes is accepted in full, but only its first `MAX_FRAME` bytes are written. The length field is `MAX_FRAME`, and status bit 5 and bit 0 are set. A frame of exactly `MAX_FRAME` bytes sets neither bit.
- R10: After write-back, the next descriptor is at the current address + 8. If the fetched status had bit 13 set, the next descriptor is at `ring_base` instead.
- R11: Once `mem_req` is raised, it stays high with address, direction and write data unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Address of the first descriptor, 16-byte aligned |
| act_wr | input | 1 | Activate register write strobe |
| act_data | input | 32 | Activate register write value; bit 24 re-arms polling |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Current byte ends the frame |
| rx_flags | input | 6 | Per-frame flags, valid with the last byte |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| rx_stalled | output | 1 | Engine parked, waiting for an activate write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte-lane write strobes |
| mem_ack | input | 1 | Access completes in this cycle; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume three things. `ring_base` is a multiple of 8 and is held constant. Buffer pointers are word aligned. The memory side eventually acknowledges every request. The stimulus uses a ring at address 0 with word-aligned buffers in 64-byte slots, and its memory model acknowledges each access exactly one cycle after the request appears. Frame flags are driven only together with the last byte, and activate writes are issued only while the engine is parked.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DESC_BYTES = 8;
  localparam int ACT_BIT    = 24;

  // status bit positions
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_LAST  = 11;
  localparam int ST_MISS  = 8;
  localparam int ST_BC    = 7;
  localparam int ST_MC    = 6;
  localparam int ST_LG    = 5;
  localparam int ST_NO    = 4;
  localparam int ST_SH    = 3;
  localparam int ST_CR    = 2;
  localparam int ST_OV    = 1;
  localparam int ST_TR    = 0;

  typedef struct packed {
    logic miss;
    logic bc;
    logic mc;
    logic nonoct;
    logic crc;
    logic ovr;
  } rx_flags_t;

  typedef enum logic [2:0] {
    S_STALL, S_FETCH0, S_FETCH1, S_RECV, S_WDATA, S_WBACK
  } eng_state_t;
endpackage

// File: rtl/rxr_status_comp.sv
module rxr_status_comp
  import rxr_pkg::*;
(
  input  logic      wrap,
  input  rx_flags_t flags,
  input  logic      oversize,
  input  logic      runt,
  output logic [15:0] status
);
  always_comb begin
    status           = '0;
    status[ST_WRAP]  = wrap;
    status[ST_LAST]  = 1'b1;
    status[ST_MISS]  = flags.miss;
    status[ST_BC]    = flags.bc;
    status[ST_MC]    = flags.mc;
    status[ST_LG]    = oversize;
    status[ST_NO]    = flags.nonoct;
    status[ST_SH]    = runt;
    status[ST_CR]    = flags.crc;
    status[ST_OV]    = flags.ovr;
    status[ST_TR]    = oversize;
  end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] desc_addr
);
  always_ff @(posedge clk) begin
    if (rst)
      desc_addr <= ring_base;
    else if (advance)
      desc_addr <= wrap ? ring_base : desc_addr + ADDR_W'(DESC_BYTES);
  end

  AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    desc_addr[2:0] == 3'b000); // R10
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 1522,
  parameter int MIN_FRAME = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              act_wr,
  input  logic [31:0]       act_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [5:0]        rx_flags,
  output logic              rx_ready,
  output logic              rx_stalled,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_FRAME);

  eng_state_t        state;
  logic [ADDR_W-1:0] desc_addr;
  logic [ADDR_W-1:0] buf_ptr;
  logic [ADDR_W-1:0] waddr;
  logic [CNT_W-1:0]  cnt;
  logic              over;
  logic              wrap_q;
  logic              last_pend;
  rx_flags_t         flags_q;
  logic [31:0]       word;
  logic [3:0]        strb;
  logic [15:0]       status_w;
  logic [1:0]        lane;
  logic              accept, store, advance, go;
  logic              unused_bits;

  assign unused_bits = ^{act_data[31:25], act_data[23:0]};
  assign lane    = cnt[1:0];
  assign accept  = rx_valid && rx_ready;
  assign store   = accept && (cnt < MAX_C);
  assign advance = (state == S_WBACK) && mem_ack;
  assign go      = act_wr && act_data[ACT_BIT];

  rxr_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .ring_base(ring_base),
    .advance(advance), .wrap(wrap_q), .desc_addr(desc_addr)
  );

  rxr_status_comp u_stat (
    .wrap(wrap_q), .flags(flags_q), .oversize(over),
    .runt(cnt < MIN_C), .status(status_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_STALL;
      buf_ptr   <= '0;
      waddr     <= '0;
      cnt       <= '0;
      over      <= 1'b0;
      wrap_q    <= 1'b0;
      last_pend <= 1'b0;
      flags_q   <= '0;
      word      <= '0;
      strb      <= '0;
    end else begin
      case (state)
        S_STALL: if (go) state <= S_FETCH0;
        S_FETCH0: if (mem_ack) begin
          wrap_q <= mem_rdata[ST_WRAP];
          state  <= mem_rdata[ST_EMPTY] ? S_FETCH1 : S_STALL;
        end
        S_FETCH1: if (mem_ack) begin
          buf_ptr   <= mem_rdata[ADDR_W-1:0];
          cnt       <= '0;
          over      <= 1'b0;
          strb      <= '0;
          last_pend <= 1'b0;
          state     <= S_RECV;
        end
        S_RECV: if (accept) begin
          if (store) begin
            word[{lane, 3'b000} +: 8] <= rx_data;
            strb[lane] <= 1'b1;
            waddr <= buf_ptr + ADDR_W'({cnt[CNT_W-1:2], 2'b00});
            cnt   <= cnt + 1'b1;
          end else begin
            over <= 1'b1;
          end
          if (rx_last) begin
            flags_q   <= rx_flags_t'(rx_flags);
            last_pend <= 1'b1;
          end
          if (store && (lane == 2'd3 || rx_last))
            state <= S_WDATA;
          else if (!store && rx_last)
            state <= (strb != 4'b0000) ? S_WDATA : S_WBACK;
        end
        S_WDATA: if (mem_ack) begin
          strb  <= '0;
          state <= last_pend ? S_WBACK : S_RECV;
        end
        S_WBACK: if (mem_ack) state <= S_FETCH0;
        default: state <= S_STALL;
      endcase
    end
  end

  assign rx_ready   = (state == S_RECV);
  assign rx_stalled = (state == S_STALL);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_wstrb = '0;
    case (state)
      S_FETCH0: mem_req = 1'b1;
      S_FETCH1: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + ADDR_W'(4);
      end
      S_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = waddr;
        mem_wdata = word;
        mem_wstrb = strb;
      end
      S_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {16'(cnt), status_w};
        mem_wstrb = 4'hF;
      end
      default: ;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (rst)
    rx_stalled && !(act_wr && act_data[ACT_BIT]) |=> rx_stalled); // R4

  AST_WB_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    state == S_WBACK |-> mem_wdata[31:16] <= 16'(MAX_FRAME)); // R9

  AST_WB_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    state == S_WBACK |-> !mem_wdata[ST_EMPTY] && mem_wdata[ST_LAST] && !rx_ready); // R6
endmodule

// File: tb/rxr_ring_writer_bench.sv
module rxr_ring_writer_bench;
  localparam int MAXF = 48;
  localparam int MINF = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ring_base = 32'h0;
  logic        act_wr = 1'b0;
  logic [31:0] act_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [5:0]  rx_flags = '0;
  logic        rx_ready, rx_stalled;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_wstrb;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxr_ring_writer #(.ADDR_W(32), .MAX_FRAME(MAXF), .MIN_FRAME(MINF)) u_rxr_ring_writer (
    .clk(clk), .rst(rst), .ring_base(ring_base), .act_wr(act_wr), .act_data(act_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_flags(rx_flags),
    .rx_ready(rx_ready), .rx_stalled(rx_stalled), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem_b [0:1023];

  typedef struct {
    logic [31:0] daddr;
    logic [15:0] status;
    logic [15:0] len;
    int          n;
    logic [7:0]  seed;
    logic [31:0] baddr;
  } exp_t;
  exp_t        exp_q[$];
  logic [63:0] wb_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // memory model: acknowledges one cycle after request, checks request holding
  logic        phase = 1'b0;
  logic [31:0] held_addr = '0;
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      phase   <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (!phase) begin
        phase     <= 1'b1;
        held_addr <= mem_addr;
      end else begin
        phase <= 1'b0;
        chk(mem_addr == held_addr, "R11 address held until ack", mem_addr, held_addr);
        mem_ack   <= 1'b1;
        mem_rdata <= {mem_b[mem_addr[9:0]+3], mem_b[mem_addr[9:0]+2],
                      mem_b[mem_addr[9:0]+1], mem_b[mem_addr[9:0]]};
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_wstrb[b]) mem_b[mem_addr[9:0]+b] = mem_wdata[b*8 +: 8];
          if (mem_addr < 32'h100) wb_q.push_back({mem_addr, mem_wdata});
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (wb_q.size() > 0) begin
        logic [63:0] w;
        exp_t e;
        bit ok;
        w = wb_q.pop_front();
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected write-back", w[63:32], 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          chk(w[63:32] == e.daddr, "R10 descriptor address", w[63:32], e.daddr);
          chk(w[15:0] == e.status, "R7 R8 R9 status word", {16'h0, w[15:0]}, {16'h0, e.status});
          chk(w[31:16] == e.len, "R6 length field", {16'h0, w[31:16]}, {16'h0, e.len});
          ok = 1;
          for (int k = 0; k < 64; k++) begin
            logic [7:0] want;
            want = (k < int'(e.len)) ? 8'(e.seed + k) : 8'hA5;
            if (mem_b[e.baddr[9:0] + k] != want) ok = 0;
          end
          chk(ok, "R5 buffer bytes and untouched tail", {31'h0, ok}, 32'h1);
        end
      end
    end
  end

  function automatic logic [15:0] exp_status(int n, logic [5:0] f, bit wrap);
    logic [15:0] s;
    s = 16'h0800;
    if (wrap) s |= 16'h2000;
    s[8] = f[5]; s[7] = f[4]; s[6] = f[3];
    s[4] = f[2]; s[2] = f[1]; s[1] = f[0];
    if (n > MAXF) s |= 16'h0021;
    if (((n > MAXF) ? MAXF : n) < MINF) s |= 16'h0008;
    return s;
  endfunction

  task automatic arm_desc(input int d);
    logic [31:0] st, bp;
    st = (d == 3) ? 32'h0000_A000 : 32'h0000_8000;
    bp = 32'h100 + 64 * d;
    for (int b = 0; b < 4; b++) begin
      mem_b[d*8 + b]     = st[b*8 +: 8];
      mem_b[d*8 + 4 + b] = bp[b*8 +: 8];
    end
    for (int k = 0; k < 64; k++) mem_b[bp[9:0] + k] = 8'hA5;
  endtask

  task automatic activate(input logic [31:0] v);
    act_wr = 1'b1; act_data = v;
    @(negedge clk);
    act_wr = 1'b0; act_data = '0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed, input logic [5:0] f, input int d);
    exp_t e;
    e.daddr  = 32'(d * 8);
    e.status = exp_status(n, f, d == 3);
    e.len    = 16'((n > MAXF) ? MAXF : n);
    e.n      = n;
    e.seed   = seed;
    e.baddr  = 32'h100 + 64 * d;
    exp_q.push_back(e);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'(seed + i);
      rx_last  = (i == n - 1);
      rx_flags = (i == n - 1) ? f : 6'h0;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_flags = '0;
  endtask

  task automatic quiet_window(input string tag);
    int reqs;
    reqs = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (mem_req || rx_ready) reqs++;
    end
    chk(reqs == 0 && rx_stalled, tag, 32'(reqs), 32'h0);
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mem_b[a] = 8'hA5;
    for (int d = 0; d < 4; d++) arm_desc(d);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_stalled == 1'b1, "R1 stalled after reset", {31'h0, rx_stalled}, 32'h1);
    chk(mem_req == 1'b0 && rx_ready == 1'b0, "R1 idle after reset", {30'h0, mem_req, rx_ready}, 32'h0);

    activate(32'h0000_0000);
    quiet_window("R2 activate without bit 24 ignored");

    activate(32'h0100_0000);
    repeat (8) @(negedge clk);
    chk(rx_ready == 1'b1, "R2 R3 empty descriptor fetched, ready", {31'h0, rx_ready}, 32'h1);

    send_frame(20, 8'h10, 6'h10, 0);   // broadcast
    send_frame(17, 8'h40, 6'h0A, 1);   // multicast + CRC, partial last word
    send_frame(10, 8'h70, 6'h25, 2);   // short, promiscuous, non-octet, overrun
    send_frame(60, 8'h90, 6'h00, 3);   // oversize, wrap descriptor
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all write-backs seen", 32'(exp_q.size()), 32'h0);
    chk(rx_stalled == 1'b1, "R4 stall on filled descriptor", {31'h0, rx_stalled}, 32'h1);
    quiet_window("R4 no access while stalled");

    arm_desc(0);
    arm_desc(1);
    activate(32'h00FF_FFFF);
    quiet_window("R2 bit 24 clear keeps stall");
    activate(32'h0100_0000);
    send_frame(48, 8'hC0, 6'h00, 0);   // exactly maximum, wraps to base
    send_frame(16, 8'hE0, 6'h00, 1);   // exactly minimum
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R10 frames after re-arm written", 32'(exp_q.size()), 32'h0);
    chk(rx_stalled == 1'b1, "R4 stall at third descriptor", {31'h0, rx_stalled}, 32'h1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule